// File: doc/BRIEF.md
# In-Order Transform Packet Sequencer

This block is the framing and ordering core of a streaming transform engine that takes variable-length packets back to back. Each packet opens with a start pulse that carries a command: a size index into a computed size table plus a forward/inverse flag. The input side never stalls. Every valid cycle is taken, and a new packet may follow the last sample of the previous one on the very next cycle, whatever its size. The arithmetic is out of scope. Samples pass through a store unchanged, and the block produces the output framing around them: valid, start-of-packet, and the echoed command.

A release model sets when each packet comes out. A packet may start once `OVERHEAD + size` cycles have passed since its start pulse. It must also wait until every sample of all earlier packets has left. A short packet queued behind a long one therefore waits for the whole long packet to drain, and it is never reordered or interleaved with it. Pending descriptors sit in a queue. A start pulse that arrives while the queue is full is dropped and reported on a one-cycle error pulse.

Top module: `seq_top`

## Requirements
- R1: Every valid input sample comes out exactly once, unchanged, in input order. Packets arrive with no idle cycle between them, and the size may change from one packet to the next.
- R2: With nothing queued or being output, the first output of a packet appears exactly `size + OVERHEAD` cycles after the cycle that sampled its start pulse.
- R3: When earlier work is pending, the first output of a packet appears in cycle max(start cycle + size + OVERHEAD, last output cycle of the previous packet + 1). The samples of a packet come out on consecutive cycles.
- R4: `outSop` is high on the first output cycle of each packet and on no other cycle. It is never high without `outValid`.
- R5: `outCmd` holds the packet's command during every output cycle of that packet. Bits [IDX_W-1:0] are the size index and bit IDX_W is the inverse flag (0 forward, 1 inverse).
- R6: `inCmd` is sampled only in a cycle with `inValid` and `inSop` both high. Its value in any other cycle has no effect on the output.
- R7: A packet with index i carries exactly `SIZE_STEP*(i+1)` samples. The input keeps `inValid` high for exactly that many cycles from the start pulse.
- R8: A start pulse that arrives while DESC_DEPTH descriptors are pending is dropped, and `descOverflow` is high for exactly the one cycle after it. No pulse occurs otherwise.
- R9: A synchronous active-high `rst` empties the descriptor queue and the sample store. Starting with the cycle after the reset edge, `outValid`, `outSop` and `descOverflow` are low until new packets come due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample valid |
| inSop | input | 1 | First sample of a packet |
| inCmd | input | IDX_W+1 | Inverse flag (MSB) and size index, sampled with inSop |
| inData | input | DATA_W | Input sample |
| outValid | output | 1 | Output sample valid |
| outSop | output | 1 | First output of a packet |
| outCmd | output | IDX_W+1 | Command of the packet being output |
| outData | output | DATA_W | Output sample |
| descOverflow | output | 1 | One-cycle pulse: a descriptor was dropped on a full queue |

## Verification
For each packet, the bench works out the cycle its first output is due: the start cycle plus size plus OVERHEAD, or one cycle after the previous packet's last output if that is later. It books every sample, start flag and command against its own output cycle in that window. Output is registered once after the release decision. The bench counts cycles on the rising edge and compares the outputs at the falling edge against that booking. A valid in a cycle with nothing booked counts as a failure. The overflow pulse is expected in the single cycle after the edge that saw the third start pulse into a two-entry queue. The reset check starts on the first cycle after the reset edge.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // strobes from the release control to the sample path
  typedef struct packed {
    logic startPkt;  // first beat of a packet is issued this cycle
    logic beat;      // one sample is issued this cycle
  } seq_strobe_t;

  function automatic int pktSize(input int idx, input int step);
    return step * (idx + 1);
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int NUM_SIZES  = 8,
  parameter int SIZE_STEP  = 12,
  parameter int OVERHEAD   = 20,
  parameter int DESC_DEPTH = 32,
  parameter int TS_W       = 16,
  parameter int CMD_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inSop,
  input  logic [CMD_W-1:0] inCmd,
  output seq_strobe_t      strobes,
  output logic [CMD_W-1:0] pktCmd,
  output logic             descOverflow
);
  localparam int IDX_W = CMD_W - 1;
  localparam int DA_W  = $clog2(DESC_DEPTH);
  localparam int CNT_W = $clog2(SIZE_STEP * NUM_SIZES + 1);

  logic [TS_W-1:0]  tick;
  logic [CMD_W-1:0] qCmd   [DESC_DEPTH];
  logic [TS_W-1:0]  qStamp [DESC_DEPTH];
  logic [DA_W-1:0]  wrPtr, rdPtr;
  logic [DA_W:0]    qCount;
  logic [CNT_W-1:0] remBeats, headSize;
  logic [TS_W-1:0]  elapsed;
  logic push, full, headValid, headReady, start;

  assign push      = inValid && inSop;
  assign full      = qCount == (DA_W+1)'(DESC_DEPTH);
  assign headValid = qCount != '0;
  assign headSize  = CNT_W'(pktSize(int'(qCmd[rdPtr][IDX_W-1:0]), SIZE_STEP));
  assign elapsed   = tick - qStamp[rdPtr];
  assign headReady = int'(elapsed) >= int'(headSize) + OVERHEAD;
  assign start     = headValid && headReady && (remBeats == '0);

  assign strobes.startPkt = start;
  assign strobes.beat     = start || (remBeats != '0);
  assign pktCmd           = qCmd[rdPtr];

  always_ff @(posedge clk) begin
    if (push && !full) begin
      qCmd[wrPtr]   <= inCmd;
      qStamp[wrPtr] <= tick;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick         <= '0;
      wrPtr        <= '0;
      rdPtr        <= '0;
      qCount       <= '0;
      remBeats     <= '0;
      descOverflow <= 1'b0;
    end else begin
      tick         <= tick + 1'b1;
      descOverflow <= push && full;
      if (push && !full) wrPtr <= wrPtr + 1'b1;
      case ({push && !full, start})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: ;
      endcase
      if (start) begin
        rdPtr    <= rdPtr + 1'b1;
        remBeats <= headSize - 1'b1;
      end else if (remBeats != '0) begin
        remBeats <= remBeats - 1'b1;
      end
    end
  end

  // R8
  desc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    qCount <= (DA_W+1)'(DESC_DEPTH));

  // R8
  ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
    descOverflow |-> ($past(qCount) == (DA_W+1)'(DESC_DEPTH)));

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CMD_W     = 4,
  parameter int SMP_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  seq_strobe_t       strobes,
  input  logic [CMD_W-1:0]  pktCmd,
  output logic              outValid,
  output logic              outSop,
  output logic [CMD_W-1:0]  outCmd,
  output logic [DATA_W-1:0] outData
);
  localparam int SA_W = $clog2(SMP_DEPTH);

  logic [DATA_W-1:0] smpMem [SMP_DEPTH];
  logic [SA_W-1:0]   wrPtr, rdPtr;
  logic [SA_W:0]     smpCount;

  always_ff @(posedge clk) begin
    if (inValid) smpMem[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      smpCount <= '0;
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outCmd   <= '0;
      outData  <= '0;
    end else begin
      outValid <= strobes.beat;
      outSop   <= strobes.startPkt;
      if (strobes.startPkt) outCmd <= pktCmd;
      if (inValid) wrPtr <= wrPtr + 1'b1;
      if (strobes.beat) begin
        outData <= smpMem[rdPtr];
        rdPtr   <= rdPtr + 1'b1;
      end
      case ({inValid, strobes.beat})
        2'b10:   smpCount <= smpCount + 1'b1;
        2'b01:   smpCount <= smpCount - 1'b1;
        default: ;
      endcase
    end
  end

  // R1
  no_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.beat |-> (smpCount != '0));

  // R4
  sop_valid_chk: assert property (@(posedge clk) disable iff (rst)
    outSop |-> outValid);

  // R4
  rise_sop_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !$past(outValid)) |-> outSop);

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && !outSop));

endmodule

// File: rtl/seq_top.sv
module seq_top
  import seq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_SIZES  = 8,
  parameter int SIZE_STEP  = 12,
  parameter int OVERHEAD   = 20,
  parameter int DESC_DEPTH = 32,
  parameter int SMP_DEPTH  = 256,
  parameter int TS_W       = 16,
  localparam int IDX_W     = $clog2(NUM_SIZES),
  localparam int CMD_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inSop,
  input  logic [CMD_W-1:0]  inCmd,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic              outSop,
  output logic [CMD_W-1:0]  outCmd,
  output logic [DATA_W-1:0] outData,
  output logic              descOverflow
);
  seq_strobe_t      strobes;
  logic [CMD_W-1:0] pktCmd;

  seq_ctrl #(
    .NUM_SIZES(NUM_SIZES), .SIZE_STEP(SIZE_STEP), .OVERHEAD(OVERHEAD),
    .DESC_DEPTH(DESC_DEPTH), .TS_W(TS_W), .CMD_W(CMD_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inSop(inSop), .inCmd(inCmd),
    .strobes(strobes), .pktCmd(pktCmd), .descOverflow(descOverflow)
  );

  seq_datapath #(
    .DATA_W(DATA_W), .CMD_W(CMD_W), .SMP_DEPTH(SMP_DEPTH)
  ) u_path (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .strobes(strobes), .pktCmd(pktCmd),
    .outValid(outValid), .outSop(outSop), .outCmd(outCmd), .outData(outData)
  );

endmodule

// File: tb/seq_top_tb.sv
module seq_top_tb;
  localparam int DW = 16, NS = 8, STEP = 12, OVH = 20, CW = 4;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic inValid = 1'b0, inSop = 1'b0, ovfEn = 1'b0;
  logic [CW-1:0] inCmd = '0;
  logic [DW-1:0] inData = '0;
  logic outValid, outSop, descOverflow;
  logic [CW-1:0] outCmd;
  logic [DW-1:0] outData;
  logic ovfValid, oValid2, oSop2, ovfFlag;
  logic [CW-1:0] oCmd2;
  logic [DW-1:0] oData2;

  assign ovfValid = inValid && ovfEn;

  seq_top #(.OVERHEAD(OVH)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSop(inSop), .inCmd(inCmd),
    .inData(inData), .outValid(outValid), .outSop(outSop), .outCmd(outCmd),
    .outData(outData), .descOverflow(descOverflow));

  seq_top #(.OVERHEAD(OVH), .DESC_DEPTH(2)) u_ovf (
    .clk(clk), .rst(rst), .inValid(ovfValid), .inSop(inSop), .inCmd(inCmd),
    .inData(inData), .outValid(oValid2), .outSop(oSop2), .outCmd(oCmd2),
    .outData(oData2), .descOverflow(ovfFlag));

  int total = 0, bad = 0, cyc = 0, lastOut = -1, ovfExpCyc = -1;
  bit monOn = 1'b0;
  logic [DW-1:0] expData [int];
  logic [CW-1:0] expCmd  [int];
  bit            expSop  [int];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // expected first output: max(start + size + OVH, previous last + 1)   (R2, R3)
  function automatic int firstDue(input int n, input int sz);
    int a = n + sz + OVH;
    return (a > lastOut + 1) ? a : lastOut + 1;
  endfunction

  task automatic sendPkt(input int idx, input bit inv, output int startCyc);
    int sz = STEP * (idx + 1);   // R7
    int first = 0;
    for (int j = 0; j < sz; j++) begin
      @(negedge clk);
      if (j == 0) begin
        startCyc = cyc + 1;
        first = firstDue(startCyc, sz);
      end
      inValid = 1'b1;
      inSop   = (j == 0);
      // R6: junk on inCmd away from the start pulse
      inCmd   = (j == 0) ? {inv, 3'(idx)} : CW'($urandom);
      inData  = DW'($urandom);
      expData[first + j] = inData;
      expCmd[first + j]  = {inv, 3'(idx)};
      expSop[first + j]  = (j == 0);
    end
    lastOut = first + sz - 1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0; inSop = 1'b0; inCmd = CW'($urandom);
    end
  endtask

  task automatic drain();
    idle(1);
    while (cyc <= lastOut + 2) @(negedge clk);
    chk(expData.size() == 0, "R3 all booked outputs seen", expData.size(), 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; inSop = 1'b0;
    repeat (3) @(negedge clk);
    expData.delete(); expCmd.delete(); expSop.delete();
    lastOut = -1;
    rst = 1'b0;
    idle(1);
  endtask

  // scoreboard at the falling edge
  always @(negedge clk) begin
    if (!rst && monOn) begin
      if (expData.exists(cyc)) begin
        chk(outValid == 1'b1, "R2 R3 valid due", outValid, 1);
        chk(outSop == expSop[cyc], "R4 sop", outSop, expSop[cyc]);
        chk(outCmd == expCmd[cyc], "R5 R6 cmd", outCmd, expCmd[cyc]);
        chk(outData == expData[cyc], "R1 R7 data", outData, expData[cyc]);
        expData.delete(cyc); expCmd.delete(cyc); expSop.delete(cyc);
      end else if (outValid || outSop) begin
        chk(1'b0, "R3 R9 unexpected valid", outValid, 0);
      end
      if (descOverflow) chk(1'b0, "R8 spurious overflow", descOverflow, 0);
      if (ovfEn) begin
        if (ovfFlag || cyc == ovfExpCyc)
          chk(ovfFlag == (cyc == ovfExpCyc), "R8 overflow pulse", ovfFlag, cyc == ovfExpCyc);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, s1, s2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(outValid == 1'b0, "R9 reset valid", outValid, 0);
    chk(outSop == 1'b0, "R9 reset sop", outSop, 0);
    chk(descOverflow == 1'b0, "R9 reset overflow", descOverflow, 0);
    rst = 1'b0;
    monOn = 1'b1;
    idle(2);

    // R2: single short packet into an empty pipeline
    sendPkt(0, 1'b0, s0);
    drain();

    // R3: short packet right behind the longest one
    sendPkt(NS - 1, 1'b1, s0);
    sendPkt(0, 1'b0, s1);
    chk(s1 == s0 + STEP * NS, "R1 no input gap", s1, s0 + STEP * NS);
    drain();

    // R1 R5: size changes back to back, flag toggles
    sendPkt(2, 1'b1, s0);
    sendPkt(5, 1'b0, s1);
    sendPkt(1, 1'b1, s2);
    sendPkt(3, 1'b0, s2);
    drain();

    // R8: two-entry queue overflows on the third start pulse
    ovfEn = 1'b1;
    sendPkt(0, 1'b0, s0);
    ovfExpCyc = s0 + 2 * STEP;
    sendPkt(0, 1'b1, s1);
    sendPkt(0, 1'b0, s2);
    drain();
    chk(ovfExpCyc == s2, "R8 third start cycle", s2, ovfExpCyc);
    ovfEn = 1'b0;
    doReset();

    // random traffic with occasional idle gaps
    for (int p = 0; p < 60; p++) begin
      sendPkt(int'($urandom_range(NS - 1)), 1'($urandom), s0);
      if ($urandom_range(3) == 0) idle(int'($urandom_range(3)) + 1);
    end
    drain();

    // R9: reset with packets in flight
    sendPkt(NS - 1, 1'b0, s0);
    sendPkt(4, 1'b1, s1);
    monOn = 1'b0;
    doReset();
    monOn = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (outValid) chk(1'b0, "R9 valid after reset", outValid, 0);
    end
    chk(outValid == 1'b0, "R9 flushed", outValid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule